// File: doc/BRIEF.md
# Chunked I2C Master Transfer Sequencer

This block turns one I2C master message of arbitrary length (1 to 255 bytes with default parameters) into a run of short hardware transactions. Each transaction carries at most four bytes. For every transaction the block fills or empties a four-entry byte buffer and hands a command word to a bit-level bus engine. The command word holds the byte count minus one, a continue flag, a repeated-start flag and the direction. The engine sits outside the block. It reads bytes to send from the buffer, or writes received bytes into it, and reports completion with the number of bytes it moved and an error indication.

A message starts with a one-cycle `start` strobe that carries the target address, the addressing mode, the direction, the length and a flag saying that another message to the same target follows. Write bytes enter on a valid/ready stream. Read bytes leave on a valid-only stream. The block formats the address bytes for the engine in both 7-bit and 10-bit modes. It rejects illegal requests before any bus activity, and it keeps the messages of a combined group on a single target. The end of every message is marked by a one-cycle `msg_done` pulse, with `msg_err` raised in the same cycle when the message failed.

Top module: `i2c_chunk_seq`

## Requirements
- R1: A message of length L is issued as ceil(L/4) commands. Every command except the last covers 4 bytes and the last covers the remainder. `cmd_cnt_m1` holds the command's byte count minus one (0 means 1 byte, 3 means 4 bytes).
- R2: `cmd_chain` is 1 on every command except the last of the message, and 0 on the last.
- R3: `cmd_rstart` is 1 only on the last command of a message whose `chained` input was 1 at start. It is never 1 together with `cmd_chain`.
- R4: For writes, all bytes of a chunk are taken from the input stream into buffer entries 0..n-1, in stream order, before that chunk's command is issued.
- R5: For reads, the bytes of a chunk leave on `rd_data`/`rd_valid` in entry order, only after the engine reports that chunk complete. `cmd_rd` is 1 for read messages.
- R6: If a chunk completes with `eng_xfer_cnt` below the requested count, the message ends with `msg_err`. A one-cycle `eng_abort` is issued first, unless that chunk was the last one and the message was not chained.
- R7: If a chunk completes with `eng_err`=1, the message ends with `msg_err` in the next cycle, with no further command and no abort.
- R8: In 7-bit mode `addr_lo` is the address shifted left by one and `addr_hi` is 0x00. In 10-bit mode `addr_lo` is address bits 7:0 and `addr_hi` is 0xF0 with address bits 9:8 placed in bits 2:1.
- R9: A start with length 0, with an address above 0x3FF, or in 7-bit mode with an address above 0x7F, ends in the next cycle with `msg_done` and `msg_err` and no command.
- R10: After a message that was started with `chained`=1 finishes without error, the next message must use the same address and mode. Otherwise it is rejected as in R9. Any error closes the group.
- R11: The buffer is cleared at the start of every accepted message, so all four entries read as 0x00 on the engine port before the first command is issued.
- R12: At most one command is outstanding. No new command is issued until the engine has pulsed `eng_done` for the previous one.
- R13: `start` is ignored while a message is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle message request, sampled only when idle |
| tgt_addr | input | AIN_W | Target address (wider than 10 bits so out-of-range values can be rejected) |
| ten_bit | input | 1 | 1 selects 10-bit addressing |
| rd | input | 1 | 1 for a read message |
| len | input | LEN_W | Message length in bytes |
| chained | input | 1 | Another message to the same target follows with a repeated start |
| wr_data | input | 8 | Write byte stream data |
| wr_valid | input | 1 | Write byte stream valid |
| wr_ready | output | 1 | Write byte accepted this cycle when valid |
| rd_data | output | 8 | Read byte stream data |
| rd_valid | output | 1 | Read byte stream valid |
| cmd_valid | output | 1 | One-cycle command strobe to the engine |
| cmd_cnt_m1 | output | 2 | Chunk byte count minus one |
| cmd_chain | output | 1 | More chunks follow without a stop |
| cmd_rstart | output | 1 | End this chunk with a repeated start instead of a stop |
| cmd_rd | output | 1 | Direction of the command |
| eng_abort | output | 1 | One-cycle abort request to the engine |
| addr_lo | output | 8 | Low address byte for the engine |
| addr_hi | output | 8 | High address byte (10-bit header) |
| addr_ten | output | 1 | Address mode of the current message |
| eng_buf_idx | input | 2 | Engine buffer entry index |
| eng_buf_rdata | output | 8 | Buffer entry selected by `eng_buf_idx` |
| eng_buf_we | input | 1 | Engine writes a received byte |
| eng_buf_wdata | input | 8 | Received byte from the engine |
| eng_done | input | 1 | Engine finished the current command |
| eng_xfer_cnt | input | 3 | Bytes the engine actually moved |
| eng_err | input | 1 | Engine reports a bus error with `eng_done` |
| msg_done | output | 1 | One-cycle end-of-message pulse |
| msg_err | output | 1 | Message failed, valid with `msg_done` |

## Verification
A wrong remaining-byte count or chunk index shows at the next `cmd_valid`, as a count field, continue flag or repeated-start flag that disagrees with the arithmetic from the message length. It also shows as a missing or extra command before `msg_done`. A corrupted buffer or a wrong entry pointer appears within the same chunk: written bytes seen through the engine port or read bytes on `rd_data` come out wrong or in the wrong order. Wrong error or group bookkeeping surfaces on the `msg_done` cycle as a wrong `msg_err`, or as an `eng_abort` pulse present or absent one cycle earlier.

// File: rtl/i2c_chunk_pkg.sv
package i2c_chunk_pkg;

  localparam int CHUNK_MAX = 4;
  localparam int IDX_W     = $clog2(CHUNK_MAX);
  localparam int CNT_W     = $clog2(CHUNK_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE,
    S_FLUSH,
    S_CHUNK,
    S_LOAD,
    S_ISSUE,
    S_WAIT,
    S_UNLOAD,
    S_NEXT,
    S_ABORT,
    S_FIN
  } seq_state_e;

  // bytes carried by the next chunk, given what is left of the message
  function automatic logic [CNT_W-1:0] chunk_take(input logic [15:0] rem);
    if (rem > 16'(CHUNK_MAX)) return CNT_W'(CHUNK_MAX);
    return rem[CNT_W-1:0];
  endfunction

  function automatic logic [7:0] addr_low(input logic [9:0] a, input logic ten);
    return ten ? a[7:0] : {a[6:0], 1'b0};
  endfunction

  // 10-bit header: 11110 followed by address bits 9:8, bit 0 left for R/W
  function automatic logic [7:0] addr_high(input logic [9:0] a, input logic ten);
    return ten ? {5'b11110, a[9:8], 1'b0} : 8'h00;
  endfunction

  function automatic logic addr_legal(input logic [15:0] a, input logic ten);
    return (a <= 16'h03FF) && (ten || (a <= 16'h007F));
  endfunction

endpackage

// File: rtl/i2c_chunk_buf.sv
module i2c_chunk_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx_a,
  output logic [DW-1:0] rdata_a,
  input  logic [IW-1:0] ridx_b,
  output logic [DW-1:0] rdata_b
);

  logic [DEPTH-1:0][DW-1:0] ent_q;
  logic                     any_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (flush)                       ent_q[i] <= '0;
        else if (we && widx == IW'(i))   ent_q[i] <= wdata;
      end
    end
  end

  assign rdata_a = ent_q[ridx_a];
  assign rdata_b = ent_q[ridx_b];
  assign any_set = |ent_q;

  // flush wins over a concurrent write and leaves every entry clear
  p_flush_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !any_set);

endmodule

// File: rtl/i2c_addr_fmt.sv
module i2c_addr_fmt
  import i2c_chunk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [9:0] addr,
  input  logic       ten,
  output logic [7:0] lo,
  output logic [7:0] hi
);

  assign lo = addr_low(addr, ten);
  assign hi = addr_high(addr, ten);

  p_ten_hdr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ten |-> (hi[7:3] == 5'b11110) && !hi[0] && (lo == addr[7:0]));

  p_seven_fmt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ten |-> (hi == 8'h00) && !lo[0]);

endmodule

// File: rtl/i2c_chunk_ctrl.sv
module i2c_chunk_ctrl
  import i2c_chunk_pkg::*;
#(
  parameter int AIN_W = 11,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AIN_W-1:0] tgt_addr,
  input  logic             ten_bit,
  input  logic             rd,
  input  logic [LEN_W-1:0] len,
  input  logic             chained,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic             ld_we,
  output logic [IDX_W-1:0] cur_idx,
  output logic             buf_flush,
  output logic             rd_valid,
  output logic             cmd_valid,
  output logic [IDX_W-1:0] cmd_cnt_m1,
  output logic             cmd_chain,
  output logic             cmd_rstart,
  output logic             cmd_rd,
  output logic             eng_abort,
  output logic [9:0]       msg_addr,
  output logic             msg_ten,
  input  logic             eng_done,
  input  logic [CNT_W-1:0] eng_xfer_cnt,
  input  logic             eng_err,
  output logic             msg_done,
  output logic             msg_err
);

  seq_state_e       st_q, st_d;
  logic [9:0]       a_q, grp_a_q;
  logic             ten_q, rd_q, chn_q, err_q;
  logic             grp_open_q, grp_ten_q;
  logic [LEN_W-1:0] rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;

  logic start_ok, last_chunk, idx_end, fin_ok;
  logic ev_reject, ev_eng_fail, ev_short, ev_short_quiet;
  logic outst_q;

  assign start_ok = (len != '0)
                 && addr_legal(16'(tgt_addr), ten_bit)
                 && (!grp_open_q || ((tgt_addr[9:0] == grp_a_q) && (ten_bit == grp_ten_q)));
  assign last_chunk = rem_q <= LEN_W'(CHUNK_MAX);
  assign idx_end    = CNT_W'(idx_q) == (cnt_q - CNT_W'(1));
  assign fin_ok     = rem_q == LEN_W'(cnt_q);

  assign ev_reject      = (st_q == S_IDLE) && start && !start_ok;
  assign ev_eng_fail    = (st_q == S_WAIT) && eng_done && eng_err;
  assign ev_short       = (st_q == S_WAIT) && eng_done && !eng_err && (eng_xfer_cnt != cnt_q);
  assign ev_short_quiet = ev_short && last_chunk && !chn_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:   if (start) st_d = start_ok ? S_FLUSH : S_FIN;
      S_FLUSH:  st_d = S_CHUNK;
      S_CHUNK:  st_d = rd_q ? S_ISSUE : S_LOAD;
      S_LOAD:   if (wr_valid && idx_end) st_d = S_ISSUE;
      S_ISSUE:  st_d = S_WAIT;
      S_WAIT: begin
        if (eng_done) begin
          if (eng_err)                   st_d = S_FIN;
          else if (eng_xfer_cnt != cnt_q) st_d = (last_chunk && !chn_q) ? S_FIN : S_ABORT;
          else                           st_d = rd_q ? S_UNLOAD : S_NEXT;
        end
      end
      S_UNLOAD: if (idx_end) st_d = S_NEXT;
      S_NEXT:   st_d = fin_ok ? S_FIN : S_CHUNK;
      S_ABORT:  st_d = S_FIN;
      S_FIN:    st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      a_q        <= '0;
      ten_q      <= 1'b0;
      rd_q       <= 1'b0;
      chn_q      <= 1'b0;
      err_q      <= 1'b0;
      rem_q      <= '0;
      cnt_q      <= '0;
      idx_q      <= '0;
      grp_open_q <= 1'b0;
      grp_a_q    <= '0;
      grp_ten_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      unique case (st_q)
        S_IDLE: begin
          if (start) begin
            a_q   <= tgt_addr[9:0];
            ten_q <= ten_bit;
            rd_q  <= rd;
            chn_q <= chained;
            rem_q <= len;
            err_q <= !start_ok;
          end
        end
        S_CHUNK: begin
          cnt_q <= chunk_take(16'(rem_q));
          idx_q <= '0;
        end
        S_LOAD:   if (wr_valid) idx_q <= idx_q + IDX_W'(1);
        S_WAIT: begin
          if (eng_done) begin
            idx_q <= '0;
            if (eng_err || (eng_xfer_cnt != cnt_q)) err_q <= 1'b1;
          end
        end
        S_UNLOAD: idx_q <= idx_q + IDX_W'(1);
        S_NEXT:   if (!fin_ok) rem_q <= rem_q - LEN_W'(cnt_q);
        S_FIN: begin
          grp_open_q <= !err_q && chn_q;
          grp_a_q    <= a_q;
          grp_ten_q  <= ten_q;
        end
        default: ;
      endcase
    end
  end

  assign wr_ready   = st_q == S_LOAD;
  assign ld_we      = wr_ready && wr_valid;
  assign cur_idx    = idx_q;
  assign buf_flush  = st_q == S_FLUSH;
  assign rd_valid   = st_q == S_UNLOAD;
  assign cmd_valid  = st_q == S_ISSUE;
  assign cmd_cnt_m1 = IDX_W'(cnt_q - CNT_W'(1));
  assign cmd_chain  = cmd_valid && !last_chunk;
  assign cmd_rstart = cmd_valid && last_chunk && chn_q;
  assign cmd_rd     = rd_q;
  assign eng_abort  = st_q == S_ABORT;
  assign msg_addr   = a_q;
  assign msg_ten    = ten_q;
  assign msg_done   = st_q == S_FIN;
  assign msg_err    = msg_done && err_q;

  // engine handshake tracker, driven from the command strobe and the engine reply
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         outst_q <= 1'b0;
    else if (cmd_valid) outst_q <= 1'b1;
    else if (eng_done)  outst_q <= 1'b0;
  end

  p_one_outstanding_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !outst_q);

  p_chain_rstart_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !(cmd_chain && cmd_rstart));

  p_abort_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |=> msg_done && msg_err);

  p_quiet_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_short_quiet |=> msg_done && msg_err && !eng_abort);

  p_fail_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eng_fail |=> msg_done && msg_err && !cmd_valid && !eng_abort);

  p_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> msg_done && msg_err);

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> !msg_done && !cmd_valid);

endmodule

// File: rtl/i2c_chunk_seq.sv
module i2c_chunk_seq
  import i2c_chunk_pkg::*;
#(
  parameter int AIN_W = 11,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AIN_W-1:0] tgt_addr,
  input  logic             ten_bit,
  input  logic             rd,
  input  logic [LEN_W-1:0] len,
  input  logic             chained,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             cmd_valid,
  output logic [IDX_W-1:0] cmd_cnt_m1,
  output logic             cmd_chain,
  output logic             cmd_rstart,
  output logic             cmd_rd,
  output logic             eng_abort,
  output logic [7:0]       addr_lo,
  output logic [7:0]       addr_hi,
  output logic             addr_ten,
  input  logic [IDX_W-1:0] eng_buf_idx,
  output logic [7:0]       eng_buf_rdata,
  input  logic             eng_buf_we,
  input  logic [7:0]       eng_buf_wdata,
  input  logic             eng_done,
  input  logic [CNT_W-1:0] eng_xfer_cnt,
  input  logic             eng_err,
  output logic             msg_done,
  output logic             msg_err
);

  logic             ld_we, buf_flush, bw_en;
  logic [IDX_W-1:0] cur_idx, bw_idx;
  logic [7:0]       bw_data;
  logic [9:0]       msg_addr;
  logic             msg_ten;

  i2c_chunk_ctrl #(.AIN_W(AIN_W), .LEN_W(LEN_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .tgt_addr     (tgt_addr),
    .ten_bit      (ten_bit),
    .rd           (rd),
    .len          (len),
    .chained      (chained),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .ld_we        (ld_we),
    .cur_idx      (cur_idx),
    .buf_flush    (buf_flush),
    .rd_valid     (rd_valid),
    .cmd_valid    (cmd_valid),
    .cmd_cnt_m1   (cmd_cnt_m1),
    .cmd_chain    (cmd_chain),
    .cmd_rstart   (cmd_rstart),
    .cmd_rd       (cmd_rd),
    .eng_abort    (eng_abort),
    .msg_addr     (msg_addr),
    .msg_ten      (msg_ten),
    .eng_done     (eng_done),
    .eng_xfer_cnt (eng_xfer_cnt),
    .eng_err      (eng_err),
    .msg_done     (msg_done),
    .msg_err      (msg_err)
  );

  // the sequencer's loader owns the write port while it fills a chunk
  assign bw_en   = ld_we || eng_buf_we;
  assign bw_idx  = ld_we ? cur_idx : eng_buf_idx;
  assign bw_data = ld_we ? wr_data : eng_buf_wdata;

  i2c_chunk_buf #(.DW(8), .DEPTH(CHUNK_MAX)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (buf_flush),
    .we      (bw_en),
    .widx    (bw_idx),
    .wdata   (bw_data),
    .ridx_a  (eng_buf_idx),
    .rdata_a (eng_buf_rdata),
    .ridx_b  (cur_idx),
    .rdata_b (rd_data)
  );

  i2c_addr_fmt u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (msg_addr),
    .ten   (msg_ten),
    .lo    (addr_lo),
    .hi    (addr_hi)
  );

  assign addr_ten = msg_ten;

endmodule

// File: tb/sim_i2c_chunk_seq.sv
module sim_i2c_chunk_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [10:0] tgt_addr = '0;
  logic        ten_bit = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  len = '0;
  logic        chained = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        cmd_valid;
  logic [1:0]  cmd_cnt_m1;
  logic        cmd_chain, cmd_rstart, cmd_rd, eng_abort;
  logic [7:0]  addr_lo, addr_hi;
  logic        addr_ten;
  logic [1:0]  eng_buf_idx = '0;
  logic [7:0]  eng_buf_rdata;
  logic        eng_buf_we = 1'b0;
  logic [7:0]  eng_buf_wdata = '0;
  logic        eng_done = 1'b0;
  logic [2:0]  eng_xfer_cnt = '0;
  logic        eng_err = 1'b0;
  logic        msg_done, msg_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int msg_id = 0;
  bit grp_open = 0;
  int grp_a = 0;
  bit grp_t = 0;

  always #10 clk = ~clk;

  i2c_chunk_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_addr(tgt_addr), .ten_bit(ten_bit),
    .rd(rd), .len(len), .chained(chained), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .cmd_valid(cmd_valid),
    .cmd_cnt_m1(cmd_cnt_m1), .cmd_chain(cmd_chain), .cmd_rstart(cmd_rstart),
    .cmd_rd(cmd_rd), .eng_abort(eng_abort), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .addr_ten(addr_ten), .eng_buf_idx(eng_buf_idx), .eng_buf_rdata(eng_buf_rdata),
    .eng_buf_we(eng_buf_we), .eng_buf_wdata(eng_buf_wdata), .eng_done(eng_done),
    .eng_xfer_cnt(eng_xfer_cnt), .eng_err(eng_err), .msg_done(msg_done), .msg_err(msg_err)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s msg %0d actual=%0h expected=%0h", req, msg_id, act, exp);
    end
  endtask

  function automatic int wbyte(input int k);
    return (k * 37 + msg_id * 11 + 5) & 255;
  endfunction
  function automatic int rbyte(input int k);
    return (k * 53 + msg_id * 7 + 60) & 255;
  endfunction
  function automatic int exp_lo(input int a, input bit t);
    return t ? (a & 255) : ((a * 2) & 255);
  endfunction
  function automatic int exp_hi(input int a, input bit t);
    return t ? (240 + ((a / 256) % 4) * 2) : 0;
  endfunction
  // bytes in chunk c of a message of length l: full chunks first, the rest last
  function automatic int piece(input int l, input int c);
    int n;
    n = (l + 3) / 4;
    return (c < n - 1) ? 4 : l - 4 * (n - 1);
  endfunction

  // fk: 0 none, 1 short count, 2 engine error, applied at chunk fc
  task automatic run_msg(input int a, input bit t, input bit r, input int l, input bit ch,
                         input int fk, input int fc, input bit poke);
    bit legal, exp_err, exp_ab, done_seen, err_seen;
    int n, exp_cmds, exp_wr, exp_rd, cmds, aborts, wptr, rptr, ph, j, xfer, cur, base;
    msg_id++;
    legal = (l != 0) && (a <= 16'h3FF) && (t || a <= 16'h7F) &&
            (!grp_open || (a == grp_a && t == grp_t));
    n = (l + 3) / 4;
    if (fk != 0 && fc >= n) fk = 0;
    exp_err  = !legal || (fk != 0);
    exp_ab   = legal && fk == 1 && (fc < n - 1 || ch);
    exp_cmds = !legal ? 0 : (fk != 0 ? fc + 1 : n);
    exp_wr   = (!legal || r) ? 0 : (fk != 0 ? 4 * fc + piece(l, fc) : l);
    exp_rd   = (!legal || !r) ? 0 : (fk != 0 ? 4 * fc : l);
    cmds = 0; aborts = 0; wptr = 0; rptr = 0; ph = 0; j = 0; xfer = 0; cur = 0; base = 0;
    done_seen = 0; err_seen = 0;
    @(negedge clk);
    start = 1; tgt_addr = 11'(a); ten_bit = t; rd = r; len = 8'(l); chained = ch;
    for (int cyc = 0; cyc < 3000 && !done_seen; cyc++) begin
      @(negedge clk);
      start = 0; eng_done = 0; eng_err = 0; eng_buf_we = 0;
      if (msg_done) begin done_seen = 1; err_seen = msg_err; end
      if (eng_abort) aborts++;
      if (rd_valid) begin
        chk(int'(rd_data) == rbyte(rptr), "R5 read byte order", rd_data, rbyte(rptr));
        rptr++;
      end
      if (wr_ready && ($urandom % 4 != 0)) begin
        wr_valid = 1; wr_data = 8'(wbyte(wptr)); wptr++;
      end else wr_valid = 0;
      if (cmd_valid) begin
        cur = piece(l, cmds); base = 4 * cmds;
        chk(int'(cmd_cnt_m1) == cur - 1, "R1 count field", cmd_cnt_m1, cur - 1);
        chk(cmd_chain == (cmds < n - 1), "R2 chain flag", cmd_chain, cmds < n - 1);
        chk(cmd_rstart == (cmds == n - 1 && ch), "R3 repeated start", cmd_rstart, cmds == n - 1 && ch);
        chk(cmd_rd == r, "R5 direction", cmd_rd, r);
        chk(int'(addr_lo) == exp_lo(a, t) && int'(addr_hi) == exp_hi(a, t) && addr_ten == t,
            "R8 address bytes", {addr_hi, addr_lo}, {exp_hi(a, t), exp_lo(a, t)});
        chk(!r || wptr == 0, "R4 no stream use on read", wptr, 0);
        if (!r) chk(wptr == base + cur, "R4 bytes loaded before command", wptr, base + cur);
        if (poke && cmds == 0) begin start = 1; len = 0; tgt_addr = 11'h7FF; end
        xfer = (fk == 1 && cmds == fc) ? cur - 1 : cur;
        ph = 1; j = 0;
        cmds++;
      end else if (ph == 1) begin
        if (r && cmds == 1) begin
          eng_buf_idx = 2'(j); #1;
          chk(eng_buf_rdata == 8'h00, "R11 buffer cleared", eng_buf_rdata, 0);
          j++;
          if (j == 4) begin ph = 2; j = 0; end
        end else if (r) begin
          ph = 2; j = 0;
        end else begin
          eng_buf_idx = 2'(j); #1;
          chk(int'(eng_buf_rdata) == wbyte(base + j), "R4 buffer entry", eng_buf_rdata, wbyte(base + j));
          j++;
          if (j == cur) begin ph = 2; j = 0; end
        end
      end else if (ph == 2) begin
        if (r && j < xfer) begin
          eng_buf_we = 1; eng_buf_idx = 2'(j); eng_buf_wdata = 8'(rbyte(base + j)); j++;
        end else begin
          eng_done = 1; eng_xfer_cnt = 3'(xfer); eng_err = (fk == 2 && cmds - 1 == fc);
          ph = 0;
        end
      end
    end
    wr_valid = 0;
    chk(done_seen, "R13 message completes", done_seen, 1);
    chk(err_seen == exp_err, legal ? "R6 R7 error flag" : "R9 R10 reject", err_seen, exp_err);
    chk(cmds == exp_cmds, "R1 R12 command count", cmds, exp_cmds);
    chk((aborts != 0) == exp_ab, "R6 abort", aborts, exp_ab);
    chk(wptr == exp_wr, "R4 stream bytes taken", wptr, exp_wr);
    chk(rptr == exp_rd, "R5 read bytes out", rptr, exp_rd);
    if (poke) chk(err_seen == exp_err && cmds == exp_cmds, "R13 start ignored while busy", err_seen, exp_err);
    grp_open = !exp_err && ch; grp_a = a; grp_t = t;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!msg_done && !msg_err && !cmd_valid && !wr_ready && !rd_valid && !eng_abort,
        "R12 reset idle", {msg_done, cmd_valid, wr_ready, rd_valid}, 0);

    // R1 R2: lengths around chunk boundaries
    run_msg(16'h50, 0, 0, 1, 0, 0, 0, 0);
    run_msg(16'h50, 0, 0, 4, 0, 0, 0, 0);
    run_msg(16'h50, 0, 0, 5, 0, 0, 0, 0);
    run_msg(16'h50, 0, 0, 9, 0, 0, 0, 0);
    // R3 R5: combined reads to one target
    run_msg(16'h22, 0, 1, 7, 1, 0, 0, 0);
    run_msg(16'h22, 0, 1, 3, 0, 0, 0, 0);
    // R8: 10-bit header
    run_msg(16'h2A5, 1, 0, 6, 0, 0, 0, 0);
    run_msg(16'h3FF, 1, 1, 4, 0, 0, 0, 0);
    // R9 rejects
    run_msg(16'h40, 0, 0, 0, 0, 0, 0, 0);
    run_msg(16'h400, 1, 0, 2, 0, 0, 0, 0);
    run_msg(16'h80, 0, 0, 2, 0, 0, 0, 0);
    // R10 group address and mode
    run_msg(16'h31, 0, 0, 2, 1, 0, 0, 0);
    run_msg(16'h32, 0, 0, 2, 0, 0, 0, 0);
    run_msg(16'h32, 0, 0, 2, 0, 0, 0, 0);
    run_msg(16'h30, 0, 1, 2, 1, 0, 0, 0);
    run_msg(16'h30, 1, 1, 2, 0, 0, 0, 0);
    // R6 short counts, R7 engine error
    run_msg(16'h11, 0, 0, 9, 0, 1, 2, 0);
    run_msg(16'h11, 0, 0, 9, 0, 1, 0, 0);
    run_msg(16'h11, 0, 1, 5, 1, 1, 1, 0);
    run_msg(16'h11, 0, 1, 6, 0, 2, 0, 0);
    run_msg(16'h11, 0, 0, 12, 0, 2, 1, 0);
    // R13 start while busy
    run_msg(16'h12, 0, 0, 8, 0, 0, 0, 1);

    for (int k = 0; k < 60; k++) begin
      int a, l, fk, fc;
      bit t, r, ch, pk;
      t  = ($urandom % 3 == 0);
      a  = t ? ($urandom % 1024) : ($urandom % 128);
      if (grp_open) begin a = grp_a; t = grp_t; end
      r  = $urandom % 2;
      l  = 1 + $urandom % 19;
      ch = ($urandom % 3 == 0);
      fk = ($urandom % 5 == 0) ? 1 + $urandom % 2 : 0;
      fc = $urandom % ((l + 3) / 4);
      pk = ($urandom % 8 == 0);
      run_msg(a, t, r, l, ch, fk, fc, pk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule